// File: doc/BRIEF.md
# Memory-Mapped Move Processor

This block is a serial processor whose only instruction is a copy. Each instruction occupies two consecutive words of memory, a source address then a destination address, and executing it moves one word from the source to the destination. Arithmetic, branching and pointer access all come from a small page of function units that sit at fixed addresses at the top of the address space. These are a program counter, a subtracting accumulator, a sign register, an index register, an indirect window addressed by the index, an input port and an output port. Every other address goes to an external single-port memory that holds both code and data.

Software builds everything else from these units. A jump is a move into the program counter. A subtraction is a move into the accumulator. A conditional is a lookup indexed by the sign value. A pointer dereference is a move into the index register followed by a move through the indirect window. Each move runs as four phases: fetch source, fetch destination, read, write. The input and output ports use valid/ready handshakes, and the machine waits on them, so there are no interrupts and no timing that software can observe beyond program order.

Top module: `mtm_core`

## Requirements
- R1: While rst_ni is low, mem_we_o, out_valid_o and in_ready_o are 0 and mem_addr_o is 0. After reset the program counter, accumulator and index register are all 0.
- R2: A move takes four phases. mem_addr_o shows the PC in the first cycle after reset and PC+1 in the second. When the destination is not the PC, the next instruction's source word is fetched from PC+2 on the fifth cycle, provided neither port waits.
- R3: Address 0xFFF0 is the PC. Writing it makes the next fetch come from the written value. Reading it returns the address of the current instruction plus 2.
- R4: Address 0xFFF1 is the accumulator. Writing value v sets it to acc - v (modulo 2^W). Reading it returns acc. Moving 0xFFF1 to 0xFFF1 clears it to 0.
- R5: Address 0xFFF2 reads as 0xFFFF when acc is negative (two's complement), 0x0000 when acc is zero and 0x0001 when acc is positive. Writes to it are discarded.
- R6: Address 0xFFF3 is the index register, readable and writable. Address 0xFFF4 reads or writes the memory word whose address is the index value.
- R7: A read of 0xFFF5 waits until in_valid_i is 1, then takes in_data_i. in_ready_o is 1 for exactly the one cycle in which the word is taken, and only while in_valid_i is 1.
- R8: A write to 0xFFF6 raises out_valid_o with the moved word on out_data_o. Both are held unchanged, and the machine waits, until out_ready_i is 1.
- R9: Addresses below 0xFFF0 read and write external memory directly. mem_we_o lasts a single cycle per write.
- R10: In the unit page, writes to 0xFFF5 and to 0xFFF7–0xFFFF are discarded, and reads of 0xFFF6 and 0xFFF7–0xFFFF return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | W | Memory address for fetch, read or write |
| mem_rdata_i | input | W | Memory read data, combinational from mem_addr_o |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | W | Memory write data |
| in_valid_i | input | 1 | Input word available |
| in_data_i | input | W | Input word |
| in_ready_o | output | 1 | Input word taken this cycle |
| out_valid_o | output | 1 | Output word presented |
| out_data_o | output | W | Output word |
| out_ready_i | input | 1 | Output word accepted this cycle |

## Verification
The only state the bench sees is what programs move out through the output port, so a program is loaded that copies each unit's value to the port after every operation. A wrong accumulator, sign or index value shows up as a wrong word one move later, which is about four cycles. A wrong program counter has two visible effects. Skipped instructions emit values that should never appear. A broken sequence shows up at once on the fetch address, within the first five cycles after reset. Handshake faults appear directly on the port pins, because the bench stalls the input for many cycles and applies backpressure to the output.

// File: rtl/mtm_pkg.sv
package mtm_pkg;
  localparam int unsigned UNIT_OFF_W = 4;

  localparam logic [UNIT_OFF_W-1:0] OFF_PC  = 4'd0;
  localparam logic [UNIT_OFF_W-1:0] OFF_SUB = 4'd1;
  localparam logic [UNIT_OFF_W-1:0] OFF_SGN = 4'd2;
  localparam logic [UNIT_OFF_W-1:0] OFF_IDX = 4'd3;
  localparam logic [UNIT_OFF_W-1:0] OFF_IND = 4'd4;
  localparam logic [UNIT_OFF_W-1:0] OFF_IN  = 4'd5;
  localparam logic [UNIT_OFF_W-1:0] OFF_OUT = 4'd6;

  typedef enum logic [3:0] {
    U_MEM, U_PC, U_SUB, U_SGN, U_IDX, U_IND, U_IN, U_OUT, U_NONE
  } unit_e;

  typedef enum logic [1:0] {
    PH_FSRC, PH_FDST, PH_READ, PH_WRITE
  } phase_e;
endpackage

// File: rtl/mtm_addr_dec.sv
module mtm_addr_dec
  import mtm_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter logic [W-UNIT_OFF_W-1:0] UNIT_PAGE = '1
) (
  input  logic [W-1:0] addr_i,
  output unit_e        unit_o
);
  localparam int unsigned PW = W - UNIT_OFF_W;

  logic [PW-1:0]         page;
  logic [UNIT_OFF_W-1:0] off;

  assign page = addr_i[W-1:UNIT_OFF_W];
  assign off  = addr_i[UNIT_OFF_W-1:0];

  always_comb begin
    if (page != UNIT_PAGE) begin
      unit_o = U_MEM;
    end else begin
      case (off)
        OFF_PC:  unit_o = U_PC;
        OFF_SUB: unit_o = U_SUB;
        OFF_SGN: unit_o = U_SGN;
        OFF_IDX: unit_o = U_IDX;
        OFF_IND: unit_o = U_IND;
        OFF_IN:  unit_o = U_IN;
        OFF_OUT: unit_o = U_OUT;
        default: unit_o = U_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mtm_fu.sv
module mtm_fu
  import mtm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  unit_e        wr_unit_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] idx_o,
  output logic [W-1:0] sgn_o
);
  logic [W-1:0] acc_q, idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (wr_en_i) begin
      if (wr_unit_i == U_SUB) acc_q <= acc_q - wdata_i;
      if (wr_unit_i == U_IDX) idx_q <= wdata_i;
    end
  end

  // sign as a two's-complement word: -1, 0, +1
  always_comb begin
    if (acc_q == '0)        sgn_o = '0;
    else if (acc_q[W-1])    sgn_o = '1;
    else                    sgn_o = W'(1);
  end

  assign acc_o = acc_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/mtm_ctrl.sv
module mtm_ctrl
  import mtm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  unit_e        src_unit_i,
  input  unit_e        dst_unit_i,
  output logic [W-1:0] src_o,
  output logic [W-1:0] dst_o,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] idx_i,
  input  logic [W-1:0] sgn_i,
  output logic         fu_wr_en_o,
  output logic [W-1:0] fu_wdata_o,
  output logic [W-1:0] mem_addr_o,
  input  logic [W-1:0] mem_rdata_i,
  output logic         mem_we_o,
  output logic [W-1:0] mem_wdata_o,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  input  logic         out_ready_i
);
  localparam logic [W-1:0] INSN_STEP = W'(2);

  phase_e       phase_q;
  logic [W-1:0] pc_q, src_q, dst_q, val_q;
  logic [W-1:0] rd_val;
  logic         rd_go, wr_go, dst_mem;

  always_comb begin
    case (src_unit_i)
      U_MEM, U_IND: rd_val = mem_rdata_i;
      U_PC:         rd_val = pc_q + INSN_STEP;
      U_SUB:        rd_val = acc_i;
      U_SGN:        rd_val = sgn_i;
      U_IDX:        rd_val = idx_i;
      U_IN:         rd_val = in_data_i;
      default:      rd_val = '0;
    endcase
  end

  assign rd_go   = (src_unit_i != U_IN) || in_valid_i;
  assign wr_go   = (dst_unit_i != U_OUT) || out_ready_i;
  assign dst_mem = (dst_unit_i == U_MEM) || (dst_unit_i == U_IND);

  always_comb begin
    case (phase_q)
      PH_FSRC: mem_addr_o = pc_q;
      PH_FDST: mem_addr_o = pc_q + W'(1);
      PH_READ: mem_addr_o = (src_unit_i == U_IND) ? idx_i : src_q;
      default: mem_addr_o = (dst_unit_i == U_IND) ? idx_i : dst_q;
    endcase
  end

  assign mem_we_o    = (phase_q == PH_WRITE) && dst_mem;
  assign mem_wdata_o = val_q;
  assign in_ready_o  = (phase_q == PH_READ) && (src_unit_i == U_IN) && in_valid_i;
  assign out_valid_o = (phase_q == PH_WRITE) && (dst_unit_i == U_OUT);
  assign out_data_o  = val_q;
  assign fu_wr_en_o  = (phase_q == PH_WRITE);
  assign fu_wdata_o  = val_q;
  assign src_o       = src_q;
  assign dst_o       = dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FSRC;
      pc_q    <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      val_q   <= '0;
    end else begin
      case (phase_q)
        PH_FSRC: begin
          src_q   <= mem_rdata_i;
          phase_q <= PH_FDST;
        end
        PH_FDST: begin
          dst_q   <= mem_rdata_i;
          phase_q <= PH_READ;
        end
        PH_READ: if (rd_go) begin
          val_q   <= rd_val;
          phase_q <= PH_WRITE;
        end
        default: if (wr_go) begin
          pc_q    <= (dst_unit_i == U_PC) ? val_q : pc_q + INSN_STEP;
          phase_q <= PH_FSRC;
        end
      endcase
    end
  end
endmodule

// File: rtl/mtm_core.sv
module mtm_core
  import mtm_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter logic [W-UNIT_OFF_W-1:0] UNIT_PAGE = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] mem_addr_o,
  input  logic [W-1:0] mem_rdata_i,
  output logic         mem_we_o,
  output logic [W-1:0] mem_wdata_o,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  input  logic         out_ready_i
);
  localparam int unsigned N_OPER = 2;

  logic [W-1:0] oper_addr [N_OPER];
  unit_e        oper_unit [N_OPER];
  logic [W-1:0] acc, idx, sgn, fu_wdata;
  logic         fu_wr_en;

  for (genvar g = 0; g < N_OPER; g++) begin : g_dec
    mtm_addr_dec #(.W(W), .UNIT_PAGE(UNIT_PAGE)) u_dec (
      .addr_i (oper_addr[g]),
      .unit_o (oper_unit[g])
    );
  end

  mtm_ctrl #(.W(W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_unit_i  (oper_unit[0]),
    .dst_unit_i  (oper_unit[1]),
    .src_o       (oper_addr[0]),
    .dst_o       (oper_addr[1]),
    .acc_i       (acc),
    .idx_i       (idx),
    .sgn_i       (sgn),
    .fu_wr_en_o  (fu_wr_en),
    .fu_wdata_o  (fu_wdata),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_ready_i (out_ready_i)
  );

  mtm_fu #(.W(W)) u_fu (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (fu_wr_en),
    .wr_unit_i (oper_unit[1]),
    .wdata_i   (fu_wdata),
    .acc_o     (acc),
    .idx_o     (idx),
    .sgn_o     (sgn)
  );
endmodule

// File: rtl/mtm_chk.sv
module mtm_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         mem_we_o,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic         out_valid_o,
  input logic         out_ready_i,
  input logic [W-1:0] out_data_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!mem_we_o && !out_valid_o && !in_ready_o);
    end
  end

  p_in_take_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> in_valid_i);

  p_in_take_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> !in_ready_o);

  p_out_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_we_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  p_we_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (!out_valid_o && !in_ready_o));
endmodule

bind mtm_core mtm_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_we_o    (mem_we_o),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o)
);

// File: tb/tb_mtm_core.sv
module tb_mtm_core;
  localparam int unsigned W = 16;
  localparam time CLK_P = 10ns;
  localparam logic [W-1:0] A_PC = 16'hFFF0, A_SUB = 16'hFFF1, A_SGN = 16'hFFF2,
    A_IDX = 16'hFFF3, A_IND = 16'hFFF4, A_IN = 16'hFFF5, A_OUT = 16'hFFF6;

  logic         clk = 0, rst_ni = 0;
  logic [W-1:0] mem_addr, mem_rdata, mem_wdata, in_data, out_data;
  logic         mem_we, in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [W-1:0] mem [0:1023];

  int n_chk = 0, n_err = 0, n_out = 0, n_take = 0, cyc = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic         prev_stall = 0;
  logic [W-1:0] prev_data = '0;

  always #(CLK_P/2) clk = ~clk;

  mtm_core dut (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .in_valid_i(in_valid),
    .in_data_i(in_data), .in_ready_o(in_ready), .out_valid_o(out_valid),
    .out_data_o(out_data), .out_ready_i(out_ready)
  );

  assign mem_rdata = mem[mem_addr[9:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;

  // output backpressure: ready two cycles of three
  always @(posedge clk) begin
    #(CLK_P/4);
    out_ready = (cyc % 3) != 0;
    cyc++;
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_out(input logic [W-1:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  task automatic put_insn(input int n, input logic [W-1:0] s, input logic [W-1:0] d);
    mem[2*n]   = s;
    mem[2*n+1] = d;
  endtask

  task automatic send_in(input logic [W-1:0] v);
    @(negedge clk);
    in_data  = v;
    in_valid = 1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_stall) begin
        check("R8 hold valid", {15'd0, out_valid}, 16'd1);
        check("R8 hold data", out_data, prev_data);
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (in_ready) n_take++;
      if (out_valid && out_ready) begin
        n_out++;
        if (exp_q.size() == 0) begin
          check("R3 unexpected output", out_data, 16'hxxxx);
        end else begin
          check(tag_q.pop_front(), out_data, exp_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem[10'h100] = 16'd5;    mem[10'h101] = 16'hFFF7; mem[10'h102] = 16'h0200;
    mem[10'h103] = 16'h0201; mem[10'h104] = 16'd40;   mem[10'h105] = 16'd7;
    mem[10'h106] = 16'd54;
    put_insn(0,  A_SUB, A_SUB);        expect_out(16'h0000, "R4 clear");
    put_insn(1,  A_SUB, A_OUT);
    put_insn(2,  A_SGN, A_OUT);        expect_out(16'h0000, "R5 zero");
    put_insn(3,  16'h0100, A_SUB);
    put_insn(4,  A_SUB, A_OUT);        expect_out(16'hFFFB, "R4 subtract");
    put_insn(5,  A_SGN, A_OUT);        expect_out(16'hFFFF, "R5 negative");
    put_insn(6,  16'h0101, A_SUB);
    put_insn(7,  A_SGN, A_OUT);        expect_out(16'h0001, "R5 positive");
    put_insn(8,  A_SUB, A_OUT);        expect_out(16'h0004, "R4 wrap");
    put_insn(9,  16'h0102, A_IDX);
    put_insn(10, A_SUB, A_IND);
    put_insn(11, 16'h0200, A_OUT);     expect_out(16'h0004, "R6 indirect write");
    put_insn(12, 16'h0100, 16'h0201);
    put_insn(13, 16'h0103, A_IDX);
    put_insn(14, A_IND, A_OUT);        expect_out(16'h0005, "R9 direct write, R6 indirect read");
    put_insn(15, A_IDX, A_OUT);        expect_out(16'h0201, "R6 index read");
    put_insn(16, A_PC, A_OUT);         expect_out(16'd34,   "R3 pc read");
    put_insn(17, 16'h0104, A_PC);
    put_insn(18, 16'h0100, A_OUT);
    put_insn(19, 16'h0100, A_OUT);
    put_insn(20, 16'h0100, A_SGN);
    put_insn(21, A_SGN, A_OUT);        expect_out(16'h0001, "R3 jump, R5 write ignored");
    put_insn(22, 16'h0105, A_IN);
    put_insn(23, A_OUT, A_OUT);        expect_out(16'h0000, "R10 out reads zero");
    put_insn(24, A_IN, A_OUT);         expect_out(16'hA5C3, "R7 input word");
    put_insn(25, A_IN, A_SUB);
    put_insn(26, A_SUB, A_OUT);        expect_out(16'h0001, "R7 second input, R10 in write ignored");
    put_insn(27, 16'h0106, A_PC);

    repeat (3) @(negedge clk);
    #1;
    check("R1 addr in reset", mem_addr, 16'h0000);
    check("R1 we in reset", {15'd0, mem_we}, 16'd0);
    check("R1 out_valid in reset", {15'd0, out_valid}, 16'd0);
    rst_ni = 1;
    #1;
    check("R2 src fetch addr", mem_addr, 16'h0000);
    @(negedge clk); #1;
    check("R2 dst fetch addr", mem_addr, 16'h0001);
    repeat (3) @(negedge clk);
    #1;
    check("R2 next insn addr", mem_addr, 16'h0002);

    wait (n_out >= 12);
    repeat (25) @(negedge clk);
    check("R7 stall without data", 16'(n_take), 16'd0);
    check("R7 no output while stalled", 16'(n_out), 16'd12);
    send_in(16'hA5C3);
    send_in(16'h0003);
    wait (n_out >= 14);
    repeat (300) @(negedge clk);
    check("R7 input takes", 16'(n_take), 16'd2);
    check("R3 all outputs seen", 16'(exp_q.size()), 16'd0);
    check("R3 output count", 16'(n_out), 16'd14);
    finish_run();
  end
endmodule